// File: doc/BRIEF.md
# Carry-Save Booth Multiply-Accumulate Unit

This block multiplies two signed operands and adds the product to a running total on every cycle that a valid strobe is high. The multiplier operand is recoded in overlapping three-bit groups, and each group selects zero, one or two times the multiplicand. Negative selections are formed by bit inversion, and the missing +1 enters the reduction as a separate correction row. The partial products, the correction row, one constant that replaces all per-row sign extension, and the stored total all reduce together in a single tree of 3:2 compressors.

The total is never turned back into a plain binary number inside the loop. It is kept as a sum vector, a carry vector and one ripple carry bit. A few low-order bits are resolved by a short ripple inside the loop, so the carry vector holds nothing below that point. A second pipeline stage adds the stored vectors over the upper bits only, and it presents the two's-complement total together with a result strobe. A clear input either restarts the total from the current product or empties it.

Top module: `csbooth_mac`

## Requirements
- R1: While rst_ni is low, and after it is released, res_o is zero and res_vld_o is low until the first valid operation has passed through.
- R2: With vld_i and clr_i both high at a rising edge, the accumulated total becomes the signed product a_i*b_i, sign-extended to ACC_W = 2N+G bits. It appears on res_o with res_vld_o high after the second rising edge, counting the sampling edge as the first.
- R3: With vld_i high and clr_i low, the signed product is added to the previous total, and res_o shows the new total two edges later.
- R4: clr_i high with vld_i low empties the total and raises no res_vld_o. A later valid operation without clear then yields its product alone.
- R5: With vld_i and clr_i both low, the stored total and res_o stay unchanged whatever a_i and b_i carry, and res_vld_o stays low for that slot.
- R6: A total that leaves the ACC_W-bit two's-complement range wraps modulo 2^ACC_W.
- R7: Products are exact for the corner operands: the most negative value, -1 (all ones), the most positive value and zero, in any pairing.
- R8: A valid operation is accepted on every cycle, and back-to-back operations each produce a result.
- R9: res_vld_o is high exactly at the edge two cycles after a valid operation was sampled, and at no other time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| vld_i | input | 1 | Accept a_i and b_i this cycle |
| clr_i | input | 1 | Drop the stored total |
| a_i | input | N | Multiplicand, two's complement |
| b_i | input | N | Multiplier, two's complement, Booth recoded |
| res_o | output | 2N+G | Resolved accumulated total |
| res_vld_o | output | 1 | res_o was updated at this edge |

## Verification
Assertions check four things on every cycle. A clear-and-load yields exactly the sign-extended product. A clear alone empties the redundant state. Idle cycles leave both the state and res_o unchanged. Every result strobe follows a valid input by two cycles. The arithmetic over long runs can only be shown by the bench's scenarios: exact accumulation of random and corner products, wrap-around after hundreds of large products, and a product-only result after an empty clear. The bench compares these against a behavioural signed multiply-accumulate model.

// File: rtl/csmac_pkg.sv
package csmac_pkg;

  typedef enum logic [1:0] {
    MAG_ZERO,
    MAG_ONE,
    MAG_TWO
  } booth_mag_e;

  // rows left after one layer of 3:2 compression
  function automatic int csa_next(input int c);
    return (c / 3) * 2 + (c % 3);
  endfunction

  function automatic int csa_levels(input int c);
    int l;
    int r;
    l = 0;
    r = c;
    while (r > 2) begin
      r = csa_next(r);
      l++;
    end
    return l;
  endfunction

  function automatic int csa_rows_at(input int c, input int lvl);
    int r;
    r = c;
    for (int i = 0; i < lvl; i++) r = csa_next(r);
    return r;
  endfunction

endpackage

// File: rtl/booth_pp_gen.sv
module booth_pp_gen
  import csmac_pkg::*;
#(
  parameter int N = 16,
  parameter int W = 40
) (
  input  logic [N-1:0]            mcand_i,
  input  logic [N-1:0]            mplier_i,
  output logic [N/2-1:0][W-1:0]   pp_o,
  output logic [W-1:0]            corr_o
);
  localparam int NPP = N / 2;

  logic [N:0]     mpl_ext;
  logic [NPP-1:0] neg_vec;

  assign mpl_ext = {mplier_i, 1'b0};

  for (genvar g = 0; g < NPP; g++) begin : g_pp
    logic [2:0] grp;
    booth_mag_e mag;
    logic       neg;
    logic [N:0] mult;
    logic [N:0] pbits;

    assign grp = mpl_ext[2*g+2 : 2*g];

    always_comb begin
      unique case (grp)
        3'b001, 3'b010: begin mag = MAG_ONE;  neg = 1'b0; end
        3'b011:         begin mag = MAG_TWO;  neg = 1'b0; end
        3'b100:         begin mag = MAG_TWO;  neg = 1'b1; end
        3'b101, 3'b110: begin mag = MAG_ONE;  neg = 1'b1; end
        default:        begin mag = MAG_ZERO; neg = 1'b0; end
      endcase
    end

    always_comb begin
      unique case (mag)
        MAG_ONE: mult = {mcand_i[N-1], mcand_i};
        MAG_TWO: mult = {mcand_i, 1'b0};
        default: mult = '0;
      endcase
    end

    // one's-complement negate; +1 goes into corr_o
    assign pbits = neg ? ~mult : mult;

    // sign bit inverted; the -2^(N+2g) part is folded into a shared constant
    assign pp_o[g] = {{(W-N-1){1'b0}}, ~pbits[N], pbits[N-1:0]} << (2*g);
    assign neg_vec[g] = neg;
  end

  always_comb begin
    corr_o = '0;
    for (int g = 0; g < NPP; g++) corr_o[2*g] = neg_vec[g];
  end

endmodule

// File: rtl/csa_tree.sv
module csa_tree
  import csmac_pkg::*;
#(
  parameter int W    = 40,
  parameter int ROWS = 13
) (
  input  logic [ROWS-1:0][W-1:0] rows_i,
  output logic [W-1:0]           sum_o,
  output logic [W-1:0]           carry_o
);
  localparam int NLEV = csa_levels(ROWS);

  logic [W-1:0] lv [NLEV+1][ROWS];

  always_comb begin
    int cnt;
    int grp;
    for (int l = 0; l <= NLEV; l++)
      for (int r = 0; r < ROWS; r++) lv[l][r] = '0;
    for (int r = 0; r < ROWS; r++) lv[0][r] = rows_i[r];
    for (int l = 0; l < NLEV; l++) begin
      cnt = csa_rows_at(ROWS, l);
      grp = cnt / 3;
      for (int g = 0; g < grp; g++) begin
        lv[l+1][2*g]   = lv[l][3*g] ^ lv[l][3*g+1] ^ lv[l][3*g+2];
        lv[l+1][2*g+1] = ((lv[l][3*g] & lv[l][3*g+1]) |
                          (lv[l][3*g] & lv[l][3*g+2]) |
                          (lv[l][3*g+1] & lv[l][3*g+2])) << 1;
      end
      for (int r = 0; r < cnt % 3; r++) lv[l+1][2*grp+r] = lv[l][3*grp+r];
    end
  end

  assign sum_o   = lv[NLEV][0];
  assign carry_o = lv[NLEV][1];

endmodule

// File: rtl/final_cpa.sv
module final_cpa #(
  parameter int W  = 40,
  parameter int LO = 4
) (
  input  logic [W-1:0]  sum_i,
  input  logic [W-1:LO] carry_hi_i,
  input  logic          cin_i,
  output logic [W-1:0]  res_o
);
  // low bits are already resolved in the loop
  assign res_o = {sum_i[W-1:LO] + carry_hi_i + (W-LO)'(cin_i), sum_i[LO-1:0]};
endmodule

// File: rtl/csbooth_mac.sv
module csbooth_mac
  import csmac_pkg::*;
#(
  parameter int N    = 16,
  parameter int G    = 8,
  parameter int LO_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              vld_i,
  input  logic              clr_i,
  input  logic [N-1:0]      a_i,
  input  logic [N-1:0]      b_i,
  output logic [2*N+G-1:0]  res_o,
  output logic              res_vld_o
);
  localparam int W    = 2 * N + G;
  localparam int NPP  = N / 2;
  localparam int ROWS = NPP + 5;

  function automatic logic [W-1:0] sign_const();
    logic [W-1:0] k;
    k = '0;
    for (int i = 0; i < NPP; i++) k = k - (W'(1) << (N + 2 * i));
    return k;
  endfunction

  localparam logic [W-1:0] SIGN_K = sign_const();

  logic [NPP-1:0][W-1:0]  pp;
  logic [W-1:0]           corr;
  logic [ROWS-1:0][W-1:0] rows;
  logic [W-1:0]           t_sum, t_carry;
  logic [LO_W:0]          lo_sum;

  logic [W-1:0]    sum_q;
  logic [W-1:LO_W] carry_hi_q;
  logic            cy_q;
  logic            acc_vld_q;
  logic [W-1:0]    acc_total;

  booth_pp_gen #(.N(N), .W(W)) u_pp (
    .mcand_i (a_i),
    .mplier_i(b_i),
    .pp_o    (pp),
    .corr_o  (corr)
  );

  always_comb begin
    for (int i = 0; i < NPP; i++) rows[i] = pp[i];
    rows[NPP]   = corr;
    rows[NPP+1] = SIGN_K;
    rows[NPP+2] = clr_i ? '0 : sum_q;
    rows[NPP+3] = clr_i ? '0 : {carry_hi_q, {LO_W{1'b0}}};
    rows[NPP+4] = clr_i ? '0 : (W'(cy_q) << LO_W);
  end

  csa_tree #(.W(W), .ROWS(ROWS)) u_tree (
    .rows_i (rows),
    .sum_o  (t_sum),
    .carry_o(t_carry)
  );

  // short ripple resolves the low bits; carry out re-enters next cycle
  assign lo_sum = {1'b0, t_sum[LO_W-1:0]} + {1'b0, t_carry[LO_W-1:0]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sum_q      <= '0;
      carry_hi_q <= '0;
      cy_q       <= 1'b0;
      acc_vld_q  <= 1'b0;
    end else begin
      acc_vld_q <= vld_i;
      if (vld_i) begin
        sum_q      <= {t_sum[W-1:LO_W], lo_sum[LO_W-1:0]};
        carry_hi_q <= t_carry[W-1:LO_W];
        cy_q       <= lo_sum[LO_W];
      end else if (clr_i) begin
        sum_q      <= '0;
        carry_hi_q <= '0;
        cy_q       <= 1'b0;
      end
    end
  end

  final_cpa #(.W(W), .LO(LO_W)) u_cpa (
    .sum_i     (sum_q),
    .carry_hi_i(carry_hi_q),
    .cin_i     (cy_q),
    .res_o     (acc_total)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_o     <= '0;
      res_vld_o <= 1'b0;
    end else begin
      res_vld_o <= acc_vld_q;
      if (acc_vld_q) res_o <= acc_total;
    end
  end

  // behavioural reference for the clear-and-load check
  logic signed [2*N-1:0] prod_ref;
  logic [W-1:0]          prod_ext;
  assign prod_ref = $signed(a_i) * $signed(b_i);
  assign prod_ext = {{G{prod_ref[2*N-1]}}, prod_ref};

  // R2
  clr_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_i && clr_i) |=> (acc_total == $past(prod_ext)));

  // R4
  clr_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !vld_i) |=> (sum_q == '0 && carry_hi_q == '0 && !cy_q));

  // R5
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!vld_i && !clr_i) |=> ($stable(sum_q) && $stable(carry_hi_q) && $stable(cy_q)));

  // R5
  res_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !res_vld_o |-> $stable(res_o));

  // R9
  vld_latency_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_vld_o |-> $past(vld_i, 2));

endmodule

// File: tb/csbooth_mac_tb.sv
`timescale 1ns/1ps
module csbooth_mac_tb;
  localparam int N = 16;
  localparam int G = 8;
  localparam int W = 2 * N + G;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         vld = 1'b0, clr = 1'b0;
  logic [N-1:0] a = '0, b = '0;
  logic [W-1:0] res;
  logic         res_vld;

  int tests = 0;
  int fails = 0;
  int seed = 32'h5eed;
  bit chk_en = 1'b0;

  logic [W-1:0] acc = '0;
  logic         cur_vld = 1'b0;
  logic [W-1:0] cur_acc = '0;
  string        cur_tag = "R1";
  logic         ev1, ev2;
  logic [W-1:0] er1, er2, exp_res;
  string        tg1, tg2;

  always #2.5 clk = ~clk;

  csbooth_mac #(.N(N), .G(G)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .vld_i(vld), .clr_i(clr),
    .a_i(a), .b_i(b), .res_o(res), .res_vld_o(res_vld)
  );

  function automatic logic [W-1:0] prod_f(input logic [N-1:0] x, input logic [N-1:0] y);
    logic signed [2*N-1:0] p;
    p = $signed(x) * $signed(y);
    return {{G{p[2*N-1]}}, p};
  endfunction

  task automatic check(input bit ok, input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  // expected pipeline: two edges from sampling to result
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ev1 <= 1'b0; ev2 <= 1'b0; er1 <= '0; er2 <= '0; exp_res <= '0;
      tg1 <= "R1"; tg2 <= "R1";
    end else begin
      ev1 <= cur_vld; er1 <= cur_acc; tg1 <= cur_tag;
      ev2 <= ev1;     er2 <= er1;     tg2 <= tg1;
      if (ev1) exp_res <= er1;
    end
  end

  always @(negedge clk) begin
    if (chk_en && rst_n) begin
      check(res_vld == ev2, "R9", W'(res_vld), W'(ev2));
      check(res == exp_res, tg2, res, exp_res);
    end
  end

  task automatic step(input bit v, input bit c, input logic [N-1:0] x, input logic [N-1:0] y, input string tag);
    @(negedge clk);
    vld = v; clr = c; a = x; b = y;
    if (c) acc = v ? prod_f(x, y) : '0;
    else if (v) acc = acc + prod_f(x, y);
    cur_vld = v; cur_acc = acc; cur_tag = tag;
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) step(1'b0, 1'b0, N'($random(seed)), N'($random(seed)), tag);
  endtask

  localparam logic [N-1:0] MNEG = {1'b1, {(N-1){1'b0}}};
  localparam logic [N-1:0] MPOS = {1'b0, {(N-1){1'b1}}};
  localparam logic [N-1:0] ONES = '1;

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL R8 watchdog act=hung exp=done");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(res == '0 && !res_vld, "R1", res, '0);
    rst_n = 1'b1;
    @(negedge clk);
    check(res == '0 && !res_vld, "R1", res, '0);
    chk_en = 1'b1;

    // R2 single clear-load then idle
    step(1, 1, N'(3), N'(-5), "R2");
    idle(3, "R5");

    // R7 corner pairs
    step(1, 1, MNEG, MNEG, "R7"); idle(2, "R7");
    step(1, 1, MNEG, MPOS, "R7"); idle(2, "R7");
    step(1, 1, ONES, ONES, "R7"); idle(2, "R7");
    step(1, 1, '0, MNEG, "R7");   idle(2, "R7");
    step(1, 1, ONES, MNEG, "R7"); idle(2, "R7");
    step(1, 1, MPOS, MPOS, "R7");
    step(1, 0, MNEG, ONES, "R7");
    step(1, 0, MPOS, MNEG, "R7"); idle(2, "R7");

    // R3 random accumulation with occasional idles
    step(1, 1, N'($random(seed)), N'($random(seed)), "R3");
    for (int i = 0; i < 300; i++) begin
      if (($random(seed) & 7) == 0) idle(1, "R5");
      else step(1, 0, N'($random(seed)), N'($random(seed)), "R3");
    end
    idle(3, "R5");

    // R4 clear alone, then product-only result
    step(0, 1, N'($random(seed)), N'($random(seed)), "R4");
    idle(2, "R4");
    step(1, 0, N'(7), N'(-9), "R4");
    idle(3, "R4");

    // R8 back-to-back with corners mixed in
    step(1, 1, MNEG, ONES, "R8");
    for (int i = 0; i < 100; i++) begin
      case ($random(seed) & 7)
        0: step(1, 0, MNEG, MNEG, "R8");
        1: step(1, 0, ONES, N'($random(seed)), "R8");
        2: step(1, 0, '0, N'($random(seed)), "R8");
        default: step(1, 0, N'($random(seed)), N'($random(seed)), "R8");
      endcase
    end
    idle(3, "R5");

    // R6 wrap: 700 * 2^30 exceeds the 40-bit signed range
    step(1, 1, MNEG, MNEG, "R6");
    for (int i = 0; i < 699; i++) step(1, 0, MNEG, MNEG, "R6");
    idle(3, "R6");
    step(1, 0, MPOS, MNEG, "R6");
    idle(3, "R6");

    chk_en = 1'b0;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule